// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast Vectors

This block gathers interrupt requests from a large set of on-chip sources plus two external active-low pins, and decides which of them the processor core should take next. Every source owns a 2-bit priority code held in a small register bank. Among the requests that are pending and enabled, the controller picks the one with the highest level, breaking ties by the lowest vector number. It then presents that vector and its level to the core on a registered output. A request is only offered when the core is idle, or when its level is strictly above the level the core is already servicing.

Two fast slots each hold a vector number and a 21-bit service address. When the winning vector matches a slot, the controller flags the grant as fast and drives the stored address, so the core can jump there without a table lookup. The register bank covers the priority codes, the pending flags, the fast-slot registers and a control word. The control word reports whether a request is being offered to the core, shows the live external pin levels, and selects edge or level sensing for each external pin. When the core acknowledges, the pending flag of an edge-latched external request is cleared.

Top module: `prio_intc`

## Requirements
- R1: After reset no request is offered (irq_valid, irq_fast low, vector, level and address zero), all priority codes, fast-slot registers and sensing bits read as zero, and the control word reads 0x000C while both external pins are high.
- R2: Source s has a 2-bit code in the register at offset s/8, bits [2*(s%8)+1 : 2*(s%8)]. Code 00 keeps the source from ever being granted. Codes 01, 10 and 11 give levels 0, 1 and 2 on irq_level.
- R3: Source s carries vector number s+2. Among eligible pending sources the highest level wins, and equal levels go to the lowest vector. With no eligible source irq_valid is low and vector and level read zero.
- R4: While core_busy is high, only sources whose level is strictly greater than core_lvl are eligible. While core_busy is low, every enabled pending source is eligible.
- R5: A change on a request input reaches the pending register at the next clock edge and the grant outputs at the edge after that. A register write changes the grant outputs at the edge that follows the write edge.
- R6: Peripheral request lines (source s = per_req bit s-2) are level-sensitive and active-high. Their pending flag follows the line one edge later.
- R7: External pin e (source e, e = 0 or 1) is active-low. Control bit e = 0 selects level sensing (pending while the pin is low). Control bit e = 1 selects edge sensing, where a high-to-low transition sets a pending flag that stays set after the pin returns high.
- R8: core_ack high at an edge while the offered vector is an edge-sensed external source clears that source's pending flag, unless a new falling edge arrives on the same edge. An acknowledge has no effect on level-sensed sources.
- R9: The fast slots use a 7-bit match register (offsets 24 and 25), a 16-bit low address register (offsets 26 and 27) and a 5-bit high address register (offsets 28 and 29). When the winning vector equals a slot's match value, irq_fast is high and irq_fast_addr = {high, low}, with slot 0 preferred over slot 1. Otherwise irq_fast_addr is zero.
- R10: Pending flags read at offsets 16 to 20, where bit b of offset 16+k is source 16k+b (vector 16k+b+2). Writes to these offsets change nothing.
- R11: The control word at offset 31 reads bit 15 = irq_valid, bit 3 = ext_irq_n[1], bit 2 = ext_irq_n[0], bits 1:0 = sensing selection. Only bits 1:0 are writable.
- R12: reg_rdata is registered: it shows the word at the address sampled on the previous edge. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| per_req | input | 78 | Peripheral request lines, active-high (sources 2 and up) |
| ext_irq_n | input | 2 | External interrupt pins, active-low (sources 0 and 1) |
| core_busy | input | 1 | Core is servicing an interrupt |
| core_lvl | input | 2 | Level the core is servicing |
| core_ack | input | 1 | Core takes the offered request |
| irq_valid | output | 1 | A request is offered to the core |
| irq_vector | output | 7 | Offered vector number |
| irq_level | output | 2 | Offered level (0 to 2) |
| irq_fast | output | 1 | Offered vector matches a fast slot |
| irq_fast_addr | output | 21 | Service address of the matching fast slot |

## Verification
The bench targets ties between equal levels, where an arbiter scanning the wrong way would grant the higher vector. It checks a core level equal to the request level, where a non-strict compare would let a request nest inside one of the same level. It exercises acknowledge on edge-latched and on level sources; a design that cleared every source would drop a held line, and one that cleared none would offer the same edge twice. It also drives both fast slots with the same vector and performs writes to read-only pending words. Here a wrong slot order or a writable pending word shows up directly as a wrong address or a wrong read-back.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int VEC_W   = 7;
  localparam int FLO_W   = 16;
  localparam int FHI_W   = 5;
  localparam int FADDR_W = FLO_W + FHI_W;
  localparam int N_FAST  = 2;
  localparam int N_EXT   = 2;

  // register word offsets
  localparam int A_PEND   = 16;
  localparam int A_FMATCH = 24;
  localparam int A_FLO    = 26;
  localparam int A_FHI    = 28;
  localparam int A_CTRL   = 31;
  localparam int CTRL_INT = 15;

  typedef struct packed {
    logic             act;
    logic [VEC_W-1:0] vec;
    logic [1:0]       lvl;
  } grant_t;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 80,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic                      irq_act,
  input  logic [N_EXT-1:0]          pin_lvl,
  output logic [2*NUM_SRC-1:0]      prio_code,
  output logic [N_FAST*VEC_W-1:0]   fmatch,
  output logic [N_FAST*FADDR_W-1:0] faddr,
  output logic [N_EXT-1:0]          edge_cfg,
  output logic [DW-1:0]             rdata
);
  localparam int FPW        = DW / 2;
  localparam int PRIO_WORDS = (NUM_SRC + FPW - 1) / FPW;
  localparam int PEND_WORDS = (NUM_SRC + DW - 1) / DW;
  localparam int PRIO_BITS  = PRIO_WORDS * DW;
  localparam int PEND_BITS  = PEND_WORDS * DW;

  logic [PRIO_BITS-1:0] prio_q;
  logic [VEC_W-1:0]     fm_q  [N_FAST];
  logic [FLO_W-1:0]     flo_q [N_FAST];
  logic [FHI_W-1:0]     fhi_q [N_FAST];
  logic [N_EXT-1:0]     edge_q;
  logic [PEND_BITS-1:0] pend_pad;
  logic [DW-1:0]        rd_mux;

  genvar w, s;
  generate
    for (w = 0; w < PRIO_WORDS; w++) begin : g_prio
      always_ff @(posedge clk) begin
        if (rst)
          prio_q[w*DW +: DW] <= '0;
        else if (we && addr == AW'(w))
          prio_q[w*DW +: DW] <= wdata;
      end
    end

    for (s = 0; s < N_FAST; s++) begin : g_fast
      always_ff @(posedge clk) begin
        if (rst) begin
          fm_q[s]  <= '0;
          flo_q[s] <= '0;
          fhi_q[s] <= '0;
        end else if (we) begin
          if (addr == AW'(A_FMATCH + s)) fm_q[s]  <= wdata[VEC_W-1:0];
          if (addr == AW'(A_FLO + s))    flo_q[s] <= wdata[FLO_W-1:0];
          if (addr == AW'(A_FHI + s))    fhi_q[s] <= wdata[FHI_W-1:0];
        end
      end
      assign fmatch[s*VEC_W +: VEC_W]     = fm_q[s];
      assign faddr[s*FADDR_W +: FADDR_W]  = {fhi_q[s], flo_q[s]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      edge_q <= '0;
    else if (we && addr == AW'(A_CTRL))
      edge_q <= wdata[N_EXT-1:0];
  end

  assign prio_code = prio_q[2*NUM_SRC-1:0];
  assign edge_cfg  = edge_q;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_SRC-1:0] = pend;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < PRIO_WORDS; i++)
      if (addr == AW'(i)) rd_mux = prio_q[i*DW +: DW];
    for (int i = 0; i < PEND_WORDS; i++)
      if (addr == AW'(A_PEND + i)) rd_mux = pend_pad[i*DW +: DW];
    for (int i = 0; i < N_FAST; i++) begin
      if (addr == AW'(A_FMATCH + i)) rd_mux = DW'(fm_q[i]);
      if (addr == AW'(A_FLO + i))    rd_mux = DW'(flo_q[i]);
      if (addr == AW'(A_FHI + i))    rd_mux = DW'(fhi_q[i]);
    end
    if (addr == AW'(A_CTRL)) begin
      rd_mux[CTRL_INT] = irq_act;
      rd_mux[3:2]      = pin_lvl;
      rd_mux[1:0]      = edge_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/prio_intc_pend.sv
module prio_intc_pend
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 80,
  parameter int VEC_BASE = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_EXT-1:0]         ext_n,
  input  logic [NUM_SRC-N_EXT-1:0] per_req,
  input  logic [N_EXT-1:0]         edge_cfg,
  input  logic                     ack,
  input  grant_t                   gnt,
  output logic [NUM_SRC-1:0]       pend
);
  logic [N_EXT-1:0]         prev_q;
  logic [N_EXT-1:0]         ext_q;
  logic [N_EXT-1:0]         ack_hit;
  logic [NUM_SRC-N_EXT-1:0] per_q;

  genvar e;
  generate
    for (e = 0; e < N_EXT; e++) begin : g_hit
      assign ack_hit[e] = ack && gnt.act && (gnt.vec == VEC_W'(VEC_BASE + e));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '1;
      ext_q  <= '0;
    end else begin
      prev_q <= ext_n;
      for (int i = 0; i < N_EXT; i++) begin
        if (!edge_cfg[i])
          ext_q[i] <= ~ext_n[i];
        else if (prev_q[i] && !ext_n[i])
          ext_q[i] <= 1'b1;
        else if (ack_hit[i])
          ext_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) per_q <= '0;
    else     per_q <= per_req;
  end

  assign pend = {per_q, ext_q};
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 80,
  parameter int VEC_BASE = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [2*NUM_SRC-1:0]      prio_code,
  input  logic                      cur_act,
  input  logic [1:0]                cur_lvl,
  input  logic [N_FAST*VEC_W-1:0]   fmatch,
  input  logic [N_FAST*FADDR_W-1:0] faddr,
  output grant_t                    gnt,
  output logic                      fast,
  output logic [FADDR_W-1:0]        fast_addr
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] elig;
  logic [1:0]         lvl [NUM_SRC];
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  logic [1:0]         win_lvl;
  logic [VEC_W-1:0]   win_vec;
  logic [N_FAST-1:0]  hit;
  logic               f_hit;
  logic [FADDR_W-1:0] f_addr;

  genvar i, s;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_elig
      assign lvl[i]  = prio_code[2*i +: 2] - 2'd1;
      assign elig[i] = pend[i] && (prio_code[2*i +: 2] != 2'b00) &&
                       (!cur_act || (lvl[i] > cur_lvl));
    end
    for (s = 0; s < N_FAST; s++) begin : g_hit
      assign hit[s] = (fmatch[s*VEC_W +: VEC_W] == win_vec);
    end
  endgenerate

  // descending scan with >= so the lowest index wins a tie
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (elig[k] && (!win_vld || lvl[k] >= win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(k);
        win_lvl = lvl[k];
      end
    end
  end

  assign win_vec = VEC_W'(win_idx) + VEC_W'(VEC_BASE);

  always_comb begin
    f_hit  = 1'b0;
    f_addr = '0;
    for (int k = N_FAST - 1; k >= 0; k--) begin
      if (win_vld && hit[k]) begin
        f_hit  = 1'b1;
        f_addr = faddr[k*FADDR_W +: FADDR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt       <= '0;
      fast      <= 1'b0;
      fast_addr <= '0;
    end else begin
      gnt.act   <= win_vld;
      gnt.vec   <= win_vld ? win_vec : '0;
      gnt.lvl   <= win_vld ? win_lvl : '0;
      fast      <= f_hit;
      fast_addr <= f_addr;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 80,
  parameter int VEC_BASE = 2,
  parameter int AW       = 5,
  parameter int DW       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            reg_addr,
  input  logic                     reg_we,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic [NUM_SRC-N_EXT-1:0] per_req,
  input  logic [N_EXT-1:0]         ext_irq_n,
  input  logic                     core_busy,
  input  logic [1:0]               core_lvl,
  input  logic                     core_ack,
  output logic                     irq_valid,
  output logic [VEC_W-1:0]         irq_vector,
  output logic [1:0]               irq_level,
  output logic                     irq_fast,
  output logic [FADDR_W-1:0]       irq_fast_addr
);
  logic [NUM_SRC-1:0]        pend;
  logic [2*NUM_SRC-1:0]      prio_code;
  logic [N_FAST*VEC_W-1:0]   fmatch;
  logic [N_FAST*FADDR_W-1:0] faddr;
  logic [N_EXT-1:0]          edge_cfg;
  grant_t                    gnt;

  prio_intc_regs #(.NUM_SRC(NUM_SRC), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend), .irq_act(gnt.act), .pin_lvl(ext_irq_n),
    .prio_code(prio_code), .fmatch(fmatch), .faddr(faddr),
    .edge_cfg(edge_cfg), .rdata(reg_rdata)
  );

  prio_intc_pend #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_pend (
    .clk(clk), .rst(rst), .ext_n(ext_irq_n), .per_req(per_req),
    .edge_cfg(edge_cfg), .ack(core_ack), .gnt(gnt), .pend(pend)
  );

  prio_intc_arb #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .prio_code(prio_code),
    .cur_act(core_busy), .cur_lvl(core_lvl), .fmatch(fmatch), .faddr(faddr),
    .gnt(gnt), .fast(irq_fast), .fast_addr(irq_fast_addr)
  );

  assign irq_valid  = gnt.act;
  assign irq_vector = gnt.vec;
  assign irq_level  = gnt.lvl;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 80,
  parameter int VEC_BASE = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               core_busy,
  input logic [1:0]         core_lvl,
  input logic               irq_valid,
  input logic [VEC_W-1:0]   irq_vector,
  input logic [1:0]         irq_level,
  input logic               irq_fast,
  input logic [FADDR_W-1:0] irq_fast_addr
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_valid && !irq_fast && irq_fast_addr == '0));

  // R2
  a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_level != 2'd3));

  // R3
  a_r3_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) < VEC_BASE + NUM_SRC));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_vector == '0 && irq_level == 2'd0));

  // R4
  a_r4_nest_above: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && $past(core_busy)) |-> (irq_level > $past(core_lvl)));

  // R9
  a_r9_fast_needs_valid: assert property (@(posedge clk) disable iff (rst)
    irq_fast |-> irq_valid);

  a_r9_addr_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_fast |-> (irq_fast_addr == '0));
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .core_busy(core_busy), .core_lvl(core_lvl),
  .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
  .irq_fast(irq_fast), .irq_fast_addr(irq_fast_addr)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  localparam int NS = 80;
  localparam int VB = 2;
  localparam int AW = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [NS-3:0] per = '0;
  logic [1:0]    ext = 2'b11;
  logic          busy = 1'b0;
  logic [1:0]    clvl = 2'd0;
  logic          ack = 1'b0;

  logic [DW-1:0] rdata;
  logic          irq_valid;
  logic [6:0]    irq_vector;
  logic [1:0]    irq_level;
  logic          irq_fast;
  logic [20:0]   irq_fast_addr;

  always #2.5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .per_req(per), .ext_irq_n(ext), .core_busy(busy),
    .core_lvl(clvl), .core_ack(ack), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level), .irq_fast(irq_fast),
    .irq_fast_addr(irq_fast_addr)
  );

  int    nvec = 0;
  int    nbad = 0;
  int    cyc = 0;
  string phase = "R1";

  task automatic chk(bit ok, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  // reference model state
  int m_prio [NS];
  bit m_pend [NS];
  bit [1:0] m_prev;
  int m_fm [2];
  int m_flo [2];
  int m_fhi [2];
  bit [1:0] m_cfg;
  bit e_valid, e_fast;
  int e_vec, e_lvl, e_addr, e_rdata;

  function automatic int rd_model(int a);
    int v = 0;
    if (a < NS / 8)
      for (int j = 0; j < 8; j++) v |= m_prio[a*8+j] << (2*j);
    else if (a >= 16 && a < 16 + NS / 16)
      for (int b = 0; b < 16; b++) v |= int'(m_pend[(a-16)*16+b]) << b;
    else if (a == 24 || a == 25) v = m_fm[a-24];
    else if (a == 26 || a == 27) v = m_flo[a-26];
    else if (a == 28 || a == 29) v = m_fhi[a-28];
    else if (a == 31) v = (int'(e_valid) << 15) | (int'(ext[1]) << 3) | (int'(ext[0]) << 2) | int'(m_cfg);
    return v;
  endfunction

  always @(posedge clk) begin : model
    int bi, bl, l, nrd, naddr;
    bit nfast;
    bit np;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_prio[i] = 0; m_pend[i] = 0; end
      for (int s = 0; s < 2; s++) begin m_fm[s] = 0; m_flo[s] = 0; m_fhi[s] = 0; end
      m_prev = 2'b11; m_cfg = 0;
      e_valid = 0; e_fast = 0; e_vec = 0; e_lvl = 0; e_addr = 0; e_rdata = 0;
    end else begin
      bi = -1; bl = 0;
      for (int i = 0; i < NS; i++) begin
        if (m_pend[i] && m_prio[i] != 0) begin
          l = m_prio[i] - 1;
          if ((!busy || l > int'(clvl)) && (bi < 0 || l > bl)) begin bi = i; bl = l; end
        end
      end
      nrd = rd_model(int'(addr));
      nfast = 0; naddr = 0;
      if (bi >= 0) begin
        for (int s = 1; s >= 0; s--)
          if (m_fm[s] == bi + VB) begin nfast = 1; naddr = m_fhi[s] * 65536 + m_flo[s]; end
      end
      for (int e = 0; e < 2; e++) begin
        np = m_pend[e];
        if (!m_cfg[e]) np = !ext[e];
        else if (m_prev[e] && !ext[e]) np = 1;
        else if (ack && e_valid && e_vec == VB + e) np = 0;
        m_pend[e] = np;
      end
      m_prev = ext;
      for (int i = 2; i < NS; i++) m_pend[i] = per[i-2];
      if (we) begin
        if (int'(addr) < NS / 8)
          for (int j = 0; j < 8; j++) m_prio[int'(addr)*8+j] = (int'(wdata) >> (2*j)) & 3;
        else if (addr == 24 || addr == 25) m_fm[int'(addr)-24] = int'(wdata) & 127;
        else if (addr == 26 || addr == 27) m_flo[int'(addr)-26] = int'(wdata);
        else if (addr == 28 || addr == 29) m_fhi[int'(addr)-28] = int'(wdata) & 31;
        else if (addr == 31) m_cfg = wdata[1:0];
      end
      e_valid = (bi >= 0);
      e_vec = (bi >= 0) ? bi + VB : 0;
      e_lvl = (bi >= 0) ? bl : 0;
      e_fast = nfast;
      e_addr = naddr;
      e_rdata = nrd;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(irq_valid === e_valid && irq_vector === e_vec[6:0] && irq_level === e_lvl[1:0],
          "grant", {irq_valid, irq_vector, irq_level}, {e_valid, e_vec[6:0], e_lvl[1:0]});
      chk(irq_fast === e_fast && irq_fast_addr === e_addr[20:0], "fast", irq_fast_addr, e_addr);
      chk(rdata === e_rdata[15:0], "rdata", rdata, e_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nbad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  int sh [NS];

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = AW'(a); we = 1'b1; wdata = DW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_prio(int s, int c);
    int w = 0;
    sh[s] = c;
    for (int j = 0; j < 8; j++) w |= sh[(s/8)*8+j] << (2*j);
    wr(s / 8, w);
  endtask

  task automatic rdchk(int a, int exp);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    chk(rdata === exp[15:0], "read", rdata, exp);
  endtask

  task automatic gchk(bit v, int vec, int lv);
    chk(irq_valid === v && irq_vector === vec[6:0] && irq_level === lv[1:0],
        "direct", {irq_valid, irq_vector, irq_level}, {v, vec[6:0], lv[1:0]});
  endtask

  initial begin
    for (int i = 0; i < NS; i++) sh[i] = 0;
    tick(3);
    rst = 1'b0;
    phase = "R1";
    tick(1);
    gchk(0, 0, 0);
    rdchk(0, 0);
    rdchk(24, 0);
    rdchk(31, 16'h000C);

    phase = "R2";
    set_prio(5, 0);
    per[3] = 1'b1;
    tick(3);
    gchk(0, 0, 0);
    set_prio(5, 3);
    tick(1);
    gchk(1, 7, 2);
    per[3] = 1'b0;
    set_prio(5, 0);

    phase = "R5";
    set_prio(20, 2);
    tick(3);
    per[18] = 1'b1;
    tick(1);
    gchk(0, 0, 0);
    tick(1);
    gchk(1, 22, 1);

    phase = "R3";
    set_prio(30, 2);
    per[28] = 1'b1;
    tick(3);
    gchk(1, 22, 1);
    set_prio(40, 3);
    per[38] = 1'b1;
    tick(3);
    gchk(1, 42, 2);

    phase = "R4";
    busy = 1'b1; clvl = 2'd1;
    tick(2);
    gchk(1, 42, 2);
    clvl = 2'd2;
    tick(2);
    gchk(0, 0, 0);
    per[38] = 1'b0;
    clvl = 2'd0;
    tick(3);
    gchk(1, 22, 1);
    clvl = 2'd1;
    tick(2);
    gchk(0, 0, 0);
    busy = 1'b0; clvl = 2'd0;

    phase = "R6";
    per = '0;
    tick(3);
    gchk(0, 0, 0);

    phase = "R7";
    set_prio(0, 2);
    set_prio(1, 1);
    ext[0] = 1'b0;
    tick(3);
    gchk(1, 2, 1);
    ext[0] = 1'b1;
    tick(3);
    gchk(0, 0, 0);
    wr(31, 3);
    ext[0] = 1'b0;
    tick(1);
    ext[0] = 1'b1;
    tick(4);
    gchk(1, 2, 1);

    phase = "R8";
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(2);
    gchk(0, 0, 0);
    per[28] = 1'b1;
    tick(3);
    gchk(1, 32, 1);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(3);
    gchk(1, 32, 1);

    phase = "R9";
    wr(24, 32);
    wr(26, 16'hBEEF);
    wr(28, 16'hFFF5);
    tick(2);
    chk(irq_fast === 1'b1 && irq_fast_addr === 21'h15BEEF, "fast0", irq_fast_addr, 21'h15BEEF);
    wr(25, 32);
    wr(27, 16'h1234);
    wr(29, 3);
    tick(2);
    chk(irq_fast === 1'b1 && irq_fast_addr === 21'h15BEEF, "both", irq_fast_addr, 21'h15BEEF);
    wr(24, 0);
    tick(2);
    chk(irq_fast === 1'b1 && irq_fast_addr === 21'h031234, "fast1", irq_fast_addr, 21'h031234);
    wr(25, 33);
    tick(2);
    chk(irq_fast === 1'b0 && irq_fast_addr === 21'h0, "nofast", irq_fast_addr, 0);

    phase = "R10";
    rdchk(17, 16'h4000);
    wr(17, 16'hFFFF);
    rdchk(17, 16'h4000);
    rdchk(16, 16'h0000);

    phase = "R11";
    wr(31, 16'hFFFF);
    rdchk(31, 16'h800F);
    ext[1] = 1'b0;
    tick(2);
    rdchk(31, 16'h8007);
    rdchk(18, 16'h0000);

    phase = "R12";
    wr(0, 16'h00A5);
    rdchk(0, 16'h00A5);
    rdchk(22, 0);
    rdchk(30, 0);
    tick(4);

    summary();
    $finish;
  end
endmodule